// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Alarm Match

This block keeps the time of day and the calendar date in packed BCD registers. The registers are seconds, minutes, hours, day of week, day of month, month and a two-digit year. They advance by one second on each cycle in which the one-second strobe `tick_1hz` is high. The strobe comes from logic outside the block, such as a crystal prescaler or a divided mains line. Hours run in either 24-hour or 12-hour form. The form is chosen by a flag packed into the hours register, next to an afternoon flag.

Software reaches every counter, three alarm compare latches, an interrupt control register and a status register through a simple register port. The port carries a select, a write strobe, a 6-bit address and a byte of data. Read data follows the address combinationally. When the seconds, minutes and hours all equal the alarm latches just after an advance, the alarm status bit is set. The active-low interrupt follows that bit only while the alarm enable is high, so software can load the time with the enable low and no interrupt fires.

Top module: `bcd_rtc_core`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the registers read as follows: seconds, minutes, hours and year 0x00; day of week, day of month and month 0x01; alarm latches, interrupt control and status 0x00; irq_n high.
- R2: Seconds and minutes count 0x00 to 0x59 in BCD. A step from 0x59 returns to 0x00 and carries into the next counter. No counter changes in a cycle without a tick or a write.
- R3: With hours bit 7 clear (24-hour form), bits 5:0 hold the BCD hour 0x00 to 0x23. A step from 0x23 returns to 0x00 and advances the date.
- R4: With hours bit 7 set (12-hour form), bits 4:0 hold the BCD hour 0x01 to 0x12 and bit 5 is the afternoon flag. The sequence is 12, 01, …, 11. Bit 5 flips on the 11→12 step, and a step from 11 with bit 5 set advances the date. Bit 6 always reads 0.
- R5: On each date advance, the day of week steps 1 to 7 and then wraps to 1.
- R6: The day of month wraps to 01 after the last day of the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on 29 when the BCD year is a multiple of 4 and on 28 otherwise. Month wraps 0x12→0x01 and advances the year; year wraps 0x99→0x00.
- R7: The register map is:
  - 0x20 to 0x26: seconds, minutes, hours, day of week, day of month, month, year.
  - 0x28, 0x29, 0x2A: alarm seconds, minutes, hours.
  - 0x2C: alarm enable in bit 0; its other bits read 0.
  - 0x2D: status, with the alarm bit in bit 0. It is read-only, so writes to it have no effect.

  Other addresses read 0x00 and ignore writes.
- R8: A write to a time counter (0x20 to 0x26) is visible on the next cycle. A tick in that same cycle is dropped, so no counter advances and no carry is produced.
- R9: In the cycle after an advance, if seconds equals alarm seconds, minutes equals alarm minutes, and hours bits 6:0 equal alarm hours bits 6:0, the status alarm bit is set. Writes alone never set it.
- R10: irq_n is low exactly while both the status alarm bit and the alarm enable are 1.
- R11: A read of 0x2D (reg_cs high, reg_we low) returns the status bit and clears it at that clock edge. If an alarm event occurs in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1hz | input | 1 | One-second advance strobe, high for one cycle |
| reg_cs | input | 1 | Register access select |
| reg_we | input | 1 | Write when high, read when low (while reg_cs is high) |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_n | output | 1 | Alarm interrupt, active low |

## Verification
The range assertions on the seconds and hour registers assume that software only writes legal BCD values within each counter's range. The stimulus loads only such values: 0x59 for seconds, 0x91 or 0xB1 for 12-hour eleven o'clock, and 0x28 for a February date. The carry assertions assume `tick_1hz` is a single-cycle strobe. The stimulus always follows a tick with at least one idle cycle, and it places writes and reads of the status register right next to ticks only where the same-cycle rules of R8 and R11 are the point of the test.

// File: rtl/rtc_pkg.sv
// Shared types, register addresses and BCD helpers for the clock/calendar.
// Assumes every counter value is legal packed BCD.
package rtc_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int N_CNT  = 7;
    localparam int IDX_W  = $clog2(N_CNT);
    localparam int N_ALM  = 3;

    typedef logic [DATA_W-1:0] bcd8_t;

    localparam int I_SEC  = 0;
    localparam int I_MIN  = 1;
    localparam int I_HOUR = 2;
    localparam int I_DOW  = 3;
    localparam int I_DOM  = 4;
    localparam int I_MON  = 5;
    localparam int I_YEAR = 6;

    localparam logic [ADDR_W-1:0] A_TIME_BASE = 6'h20;
    localparam logic [ADDR_W-1:0] A_TIME_LAST = 6'h26;
    localparam logic [ADDR_W-1:0] A_ALM_BASE  = 6'h28;
    localparam logic [ADDR_W-1:0] A_IRQ_CTL   = 6'h2C;
    localparam logic [ADDR_W-1:0] A_STATUS    = 6'h2D;

    // One BCD step up; caller handles the wrap value.
    function automatic bcd8_t bcd_inc(input bcd8_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two-digit BCD year divisible by four.
    function automatic logic is_leap(input bcd8_t y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    // Last day of month m in year y, BCD.
    function automatic bcd8_t month_last(input bcd8_t m, input bcd8_t y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Reset value of counter i.
    function automatic bcd8_t reset_val(input int i);
        if (i == I_DOW || i == I_DOM || i == I_MON) return 8'h01;
        return 8'h00;
    endfunction
endpackage

// File: rtl/rtc_time_chain.sv
// Seven cascaded BCD counters: seconds, minutes, hours (12/24 form), day of
// week, day of month, month, year. Advances once per cycle with adv high.
// A write loads one counter and the caller keeps adv low in that cycle.
// Assumes written values are legal BCD for the counter.
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         adv,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  bcd8_t                        wr_data,
    output logic [N_CNT-1:0][DATA_W-1:0] cnt
);
    bcd8_t              nxt [N_CNT];
    logic [N_CNT-1:0]   step;
    logic               day_carry;
    bcd8_t              h12, h24, hinc12, hinc24, last_day;

    // Next value of every counter and the step enables of the carry chain.
    always_comb begin
        h12      = {3'b000, cnt[I_HOUR][4:0]};
        h24      = {2'b00, cnt[I_HOUR][5:0]};
        hinc12   = bcd_inc(h12);
        hinc24   = bcd_inc(h24);
        last_day = month_last(cnt[I_MON], cnt[I_YEAR]);
        day_carry = 1'b0;
        if (cnt[I_HOUR][7]) begin
            if (h12 == 8'h12) begin
                nxt[I_HOUR] = {2'b10, cnt[I_HOUR][5], 5'h01};
            end else if (h12 == 8'h11) begin
                nxt[I_HOUR] = {2'b10, ~cnt[I_HOUR][5], 5'h12};
                day_carry   = cnt[I_HOUR][5];
            end else begin
                nxt[I_HOUR] = {2'b10, cnt[I_HOUR][5], hinc12[4:0]};
            end
        end else begin
            if (h24 == 8'h23) begin
                nxt[I_HOUR] = 8'h00;
                day_carry   = 1'b1;
            end else begin
                nxt[I_HOUR] = hinc24;
            end
        end
        nxt[I_SEC]  = (cnt[I_SEC] == 8'h59)  ? 8'h00 : bcd_inc(cnt[I_SEC]);
        nxt[I_MIN]  = (cnt[I_MIN] == 8'h59)  ? 8'h00 : bcd_inc(cnt[I_MIN]);
        nxt[I_DOW]  = (cnt[I_DOW] == 8'h07)  ? 8'h01 : bcd_inc(cnt[I_DOW]);
        nxt[I_DOM]  = (cnt[I_DOM] == last_day) ? 8'h01 : bcd_inc(cnt[I_DOM]);
        nxt[I_MON]  = (cnt[I_MON] == 8'h12)  ? 8'h01 : bcd_inc(cnt[I_MON]);
        nxt[I_YEAR] = (cnt[I_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cnt[I_YEAR]);

        step[I_SEC]  = adv;
        step[I_MIN]  = step[I_SEC] && (cnt[I_SEC] == 8'h59);
        step[I_HOUR] = step[I_MIN] && (cnt[I_MIN] == 8'h59);
        step[I_DOW]  = step[I_HOUR] && day_carry;
        step[I_DOM]  = step[I_HOUR] && day_carry;
        step[I_MON]  = step[I_DOM] && (cnt[I_DOM] == last_day);
        step[I_YEAR] = step[I_MON] && (cnt[I_MON] == 8'h12);
    end

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        // Load, advance or hold counter i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[i] <= reset_val(i);
            else if (wr_en && wr_idx == IDX_W'(i))
                cnt[i] <= (i == I_HOUR) ? (wr_data & 8'hBF) : wr_data;
            else if (step[i])
                cnt[i] <= nxt[i];
        end
    end

    // R2: seconds stay legal BCD in range
    a_r2_sec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[I_SEC][3:0] <= 4'd9 && cnt[I_SEC] <= 8'h59);
    // R2: nothing moves without tick or write
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr_en) |=> $stable(cnt));
    // R2: seconds wrap to zero
    a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt[I_SEC] == 8'h59) |=> cnt[I_SEC] == 8'h00);
    // R4: afternoon flag flips on 11 -> 12
    a_r4_pm_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt[I_HOUR][7] && cnt[I_HOUR][4:0] == 5'h11 &&
         cnt[I_MIN] == 8'h59 && cnt[I_SEC] == 8'h59)
        |=> cnt[I_HOUR][5] != $past(cnt[I_HOUR][5]));
    // R4: bit 6 of hours never set
    a_r4_bit6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt[I_HOUR][6]);
    // R8: a seconds write carries nothing into minutes
    a_r8_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(I_SEC)) |=> cnt[I_MIN] == $past(cnt[I_MIN]));
endmodule

// File: rtl/rtc_alarm_unit.sv
// Alarm latches, enable, sticky status bit and active-low interrupt.
// Compares latches with the live time one cycle after each advance.
// Assumes the caller raises adv only on a real advance (not on writes).
module rtc_alarm_unit
    import rtc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         adv,
    input  logic [N_ALM-1:0]             latch_we,
    input  logic                         ctl_we,
    input  bcd8_t                        wr_data,
    input  logic                         rd_status,
    input  bcd8_t                        sec_now,
    input  bcd8_t                        min_now,
    input  logic [6:0]                   hour_now,
    output logic [N_ALM-1:0][DATA_W-1:0] alm,
    output logic                         alm_en,
    output logic                         alm_flag,
    output logic                         irq_n
);
    logic adv_q;
    logic match;
    logic hit;

    for (genvar i = 0; i < N_ALM; i++) begin : g_lat
        // Load alarm latch i from the register port.
        always_ff @(posedge clk) begin
            if (!rst_n)          alm[i] <= '0;
            else if (latch_we[i]) alm[i] <= wr_data;
        end
    end

    // Remember that the counters advanced last cycle; hold the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_q  <= 1'b0;
            alm_en <= 1'b0;
        end else begin
            adv_q <= adv;
            if (ctl_we) alm_en <= wr_data[0];
        end
    end

    // Compare latches with the live seconds, minutes and hours.
    always_comb begin
        match = (alm[0] == sec_now) && (alm[1] == min_now) &&
                (alm[2][6:0] == hour_now);
        hit   = adv_q && match;
    end

    // Sticky status bit: set on a hit, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)         alm_flag <= 1'b0;
        else if (hit)       alm_flag <= 1'b1;
        else if (rd_status) alm_flag <= 1'b0;
    end

    assign irq_n = ~(alm_flag & alm_en);

    // R9: status bit only rises after a post-advance match
    a_r9_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> $past(adv_q && match));
    // R11: read clears when no event competes
    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !(adv_q && match)) |=> !alm_flag);
    // R11: event wins over a simultaneous read
    a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_q && match) |=> alm_flag);
endmodule

// File: rtl/bcd_rtc_core.sv
// Top of the BCD clock/calendar: register decode, read mux, counter chain
// and alarm unit. Read data follows reg_addr combinationally; side effects
// (writes, status clear) happen at the clock edge while reg_cs is high.
// Assumes tick_1hz is a single-cycle strobe.
module bcd_rtc_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              reg_cs,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n
);
    logic [N_CNT-1:0][DATA_W-1:0] cnt;
    logic [N_ALM-1:0][DATA_W-1:0] alm;
    logic [N_ALM-1:0]             latch_we;
    logic                         acc_wr, acc_rd, time_hit, tc_wr, adv;
    logic                         ctl_we, rd_status, alm_en, alm_flag;
    logic [IDX_W-1:0]             tc_idx;
    logic [IDX_W-1:0]             alm_idx;
    logic                         alm_hit;

    // Decode the access into counter, latch, control and status strobes.
    always_comb begin
        acc_wr    = reg_cs && reg_we;
        acc_rd    = reg_cs && !reg_we;
        time_hit  = (reg_addr >= A_TIME_BASE) && (reg_addr <= A_TIME_LAST);
        tc_idx    = IDX_W'(reg_addr - A_TIME_BASE);
        alm_hit   = (reg_addr >= A_ALM_BASE) &&
                    (reg_addr < A_ALM_BASE + ADDR_W'(N_ALM));
        alm_idx   = IDX_W'(reg_addr - A_ALM_BASE);
        tc_wr     = acc_wr && time_hit;
        adv       = tick_1hz && !tc_wr;
        ctl_we    = acc_wr && (reg_addr == A_IRQ_CTL);
        rd_status = acc_rd && (reg_addr == A_STATUS);
    end

    for (genvar i = 0; i < N_ALM; i++) begin : g_lwe
        assign latch_we[i] = acc_wr && (reg_addr == A_ALM_BASE + ADDR_W'(i));
    end

    // Read multiplexer over counters, latches, control and status.
    always_comb begin
        reg_rdata = '0;
        if (time_hit)                    reg_rdata = cnt[tc_idx];
        else if (alm_hit)                reg_rdata = alm[alm_idx];
        else if (reg_addr == A_IRQ_CTL)  reg_rdata = {7'b0, alm_en};
        else if (reg_addr == A_STATUS)   reg_rdata = {7'b0, alm_flag};
    end

    rtc_time_chain u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .wr_en   (tc_wr),
        .wr_idx  (tc_idx),
        .wr_data (reg_wdata),
        .cnt     (cnt)
    );

    rtc_alarm_unit u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .latch_we  (latch_we),
        .ctl_we    (ctl_we),
        .wr_data   (reg_wdata),
        .rd_status (rd_status),
        .sec_now   (cnt[I_SEC]),
        .min_now   (cnt[I_MIN]),
        .hour_now  (cnt[I_HOUR][6:0]),
        .alm       (alm),
        .alm_en    (alm_en),
        .alm_flag  (alm_flag),
        .irq_n     (irq_n)
    );

    // R8: a tick coinciding with a time write is dropped
    a_r8_tick_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_wr && tc_idx != IDX_W'(I_SEC)) |=> cnt[I_SEC] == $past(cnt[I_SEC]));
    // R10: interrupt low implies enable set
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($rose(alm_flag) || $rose(alm_en)));
endmodule

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cs = 1'b0;
    logic       we = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;

    always #10 clk = ~clk;

    bcd_rtc_core uut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .reg_cs(cs), .reg_we(we),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_n(irq_n)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    live = 0;
    string cur_req = "R1";

    // behavioural reference state (binary integers)
    int         m_sec, m_min, m_h24, m_dow, m_dom, m_mon, m_yr;
    bit         m_12, m_en, m_flag, m_adv, ev, twr, advn;
    logic [7:0] m_alm [3];

    function automatic logic [7:0] tobcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction
    function automatic int frombcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction
    function automatic logic [7:0] hour_byte();
        int h;
        if (!m_12) return tobcd(m_h24);
        h = m_h24 % 12;
        if (h == 0) h = 12;
        return 8'h80 | (m_h24 >= 12 ? 8'h20 : 8'h00) | tobcd(h);
    endfunction
    function automatic int mdays();
        if (m_mon == 2) return (m_yr % 4 == 0) ? 29 : 28;
        if (m_mon == 4 || m_mon == 6 || m_mon == 9 || m_mon == 11) return 30;
        return 31;
    endfunction
    function automatic logic [7:0] model_rd(input logic [5:0] a);
        case (a)
            6'h20: return tobcd(m_sec);
            6'h21: return tobcd(m_min);
            6'h22: return hour_byte();
            6'h23: return tobcd(m_dow);
            6'h24: return tobcd(m_dom);
            6'h25: return tobcd(m_mon);
            6'h26: return tobcd(m_yr);
            6'h28: return m_alm[0];
            6'h29: return m_alm[1];
            6'h2A: return m_alm[2];
            6'h2C: return {7'b0, m_en};
            6'h2D: return {7'b0, m_flag};
            default: return 8'h00;
        endcase
    endfunction

    task automatic advance();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_h24++;
                if (m_h24 == 24) begin
                    m_h24 = 0;
                    m_dow = m_dow % 7 + 1;
                    m_dom++;
                    if (m_dom > mdays()) begin
                        m_dom = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1; m_yr = (m_yr + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic model_write(input logic [5:0] a, input logic [7:0] d);
        case (a)
            6'h20: m_sec = frombcd(d);
            6'h21: m_min = frombcd(d);
            6'h22: begin
                m_12 = d[7];
                if (d[7]) m_h24 = frombcd({3'b0, d[4:0]}) % 12 + (d[5] ? 12 : 0);
                else      m_h24 = frombcd({2'b0, d[5:0]});
            end
            6'h23: m_dow = frombcd(d);
            6'h24: m_dom = frombcd(d);
            6'h25: m_mon = frombcd(d);
            6'h26: m_yr  = frombcd(d);
            6'h28: m_alm[0] = d;
            6'h29: m_alm[1] = d;
            6'h2A: m_alm[2] = d;
            6'h2C: m_en = d[0];
            default: ;
        endcase
    endtask

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_h24 = 0; m_12 = 0;
            m_dow = 1; m_dom = 1; m_mon = 1; m_yr = 0;
            m_alm[0] = 0; m_alm[1] = 0; m_alm[2] = 0;
            m_en = 0; m_flag = 0; m_adv = 0;
        end else begin
            ev = m_adv && tobcd(m_sec) == m_alm[0] && tobcd(m_min) == m_alm[1] &&
                 (hour_byte() & 8'h7F) == (m_alm[2] & 8'h7F);
            twr = cs && we && addr >= 6'h20 && addr <= 6'h26;
            if (ev) m_flag = 1;
            else if (cs && !we && addr == 6'h2D) m_flag = 0;
            advn = tick && !twr;
            if (advn) advance();
            if (cs && we) model_write(addr, wdata);
            m_adv = advn;
        end
    end

    task automatic chk(input string r, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (t=%0t)", r, got, exp, $time);
        end
    endtask

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (live) begin
            chk(cur_req, rdata, model_rd(addr));
            chk(cur_req, {7'b0, irq_n}, {7'b0, ~(m_flag & m_en)});
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic put(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); #1; cs = 1; we = 1; addr = a; wdata = d; tick = 0;
        @(negedge clk); #1; cs = 0; we = 0;
    endtask
    task automatic put_tick(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); #1; cs = 1; we = 1; addr = a; wdata = d; tick = 1;
        @(negedge clk); #1; cs = 0; we = 0; tick = 0;
    endtask
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1; tick = 1;
            @(negedge clk); #1; tick = 0;
        end
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask
    task automatic expect_at(input logic [5:0] a, input logic [7:0] e, input string r);
        @(negedge clk); #1; cs = 0; addr = a; #4; chk(r, rdata, e);
    endtask
    task automatic expect_irq(input logic e, input string r);
        @(negedge clk); #5; chk(r, {7'b0, irq_n}, {7'b0, e});
    endtask
    task automatic read_status(input logic [7:0] e, input string r);
        @(negedge clk); #1; cs = 1; we = 0; addr = 6'h2D; #4; chk(r, rdata, e);
        @(negedge clk); #1; cs = 0;
    endtask
    task automatic tick_then_read(input logic [7:0] e, input string r);
        @(negedge clk); #1; tick = 1;
        @(negedge clk); #1; tick = 0; cs = 1; we = 0; addr = 6'h2D; #4; chk(r, rdata, e);
        @(negedge clk); #1; cs = 0;
    endtask
    task automatic set_date(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d);
        put(6'h26, y); put(6'h25, mo); put(6'h24, d);
    endtask
    task automatic set_time(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
        put(6'h22, h); put(6'h21, mi); put(6'h20, s);
    endtask

    initial begin
        idle(3);
        @(negedge clk); #1; rst_n = 1;
        live = 1;

        cur_req = "R1";
        expect_at(6'h20, 8'h00, "R1"); expect_at(6'h22, 8'h00, "R1");
        expect_at(6'h23, 8'h01, "R1"); expect_at(6'h24, 8'h01, "R1");
        expect_at(6'h25, 8'h01, "R1"); expect_at(6'h26, 8'h00, "R1");
        expect_at(6'h2A, 8'h00, "R1"); expect_at(6'h2D, 8'h00, "R1");
        expect_irq(1'b1, "R1");

        cur_req = "R2";
        put(6'h21, 8'h12); put(6'h20, 8'h57);
        ticks(5);
        expect_at(6'h20, 8'h02, "R2"); expect_at(6'h21, 8'h13, "R2");
        idle(10);
        expect_at(6'h20, 8'h02, "R2");

        cur_req = "R3";
        put(6'h23, 8'h07); set_date(8'h99, 8'h12, 8'h31);
        set_time(8'h23, 8'h59, 8'h58);
        ticks(3);
        expect_at(6'h22, 8'h00, "R3"); expect_at(6'h20, 8'h01, "R3");
        expect_at(6'h23, 8'h01, "R5");
        expect_at(6'h24, 8'h01, "R6"); expect_at(6'h25, 8'h01, "R6");
        expect_at(6'h26, 8'h00, "R6");

        cur_req = "R6";
        set_date(8'h24, 8'h02, 8'h28); set_time(8'h23, 8'h59, 8'h59); ticks(1);
        expect_at(6'h24, 8'h29, "R6");
        set_time(8'h23, 8'h59, 8'h59); ticks(1);
        expect_at(6'h24, 8'h01, "R6"); expect_at(6'h25, 8'h03, "R6");
        set_date(8'h23, 8'h02, 8'h28); set_time(8'h23, 8'h59, 8'h59); ticks(1);
        expect_at(6'h24, 8'h01, "R6"); expect_at(6'h25, 8'h03, "R6");
        set_date(8'h05, 8'h04, 8'h30); set_time(8'h23, 8'h59, 8'h59); ticks(1);
        expect_at(6'h24, 8'h01, "R6"); expect_at(6'h25, 8'h05, "R6");

        cur_req = "R4";
        set_time(8'h91, 8'h59, 8'h59); ticks(1);
        expect_at(6'h22, 8'hB2, "R4");
        set_time(8'hB1, 8'h59, 8'h59); ticks(1);
        expect_at(6'h22, 8'h92, "R4"); expect_at(6'h24, 8'h02, "R4");
        set_time(8'h92, 8'h59, 8'h59); ticks(1);
        expect_at(6'h22, 8'h81, "R4");
        put(6'h22, 8'hC5);
        expect_at(6'h22, 8'h85, "R4");
        put(6'h22, 8'h10);

        cur_req = "R8";
        put(6'h21, 8'h20); put(6'h20, 8'h59);
        put_tick(6'h21, 8'h10);
        expect_at(6'h20, 8'h59, "R8"); expect_at(6'h21, 8'h10, "R8");
        put_tick(6'h20, 8'h30);
        expect_at(6'h20, 8'h30, "R8");

        cur_req = "R11";
        read_status({7'b0, m_flag}, "R11");
        cur_req = "R9";
        put(6'h28, 8'h05); put(6'h29, 8'h30); put(6'h2A, 8'h08); put(6'h2C, 8'h00);
        set_time(8'h08, 8'h30, 8'h03); ticks(2);
        expect_at(6'h2D, 8'h01, "R9");
        cur_req = "R10";
        expect_irq(1'b1, "R10");
        put(6'h2C, 8'h01);
        expect_irq(1'b0, "R10"); expect_at(6'h2C, 8'h01, "R7");
        cur_req = "R11";
        read_status(8'h01, "R11");
        expect_irq(1'b1, "R11"); expect_at(6'h2D, 8'h00, "R11");
        cur_req = "R9";
        set_time(8'h08, 8'h30, 8'h05); idle(3);
        expect_at(6'h2D, 8'h00, "R9");
        cur_req = "R7";
        put(6'h2D, 8'hFF); expect_at(6'h2D, 8'h00, "R7");
        put(6'h3F, 8'hAA); expect_at(6'h3F, 8'h00, "R7");
        put(6'h2C, 8'hFF); expect_at(6'h2C, 8'h01, "R7");
        cur_req = "R11";
        put(6'h20, 8'h04);
        tick_then_read(8'h00, "R11");
        expect_at(6'h2D, 8'h01, "R11"); expect_irq(1'b0, "R10");

        idle(4);
        live = 0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule